// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller collects every exception and interrupt request of a small system and decides which one is serviced next. It then presents the vector for that request to one of two handlers: the main processor or a coprocessor. Three reset requests come first. Six fixed non-maskable traps come next: an unimplemented-opcode trap, a software or debug-entry request, a system-call trap and three access-violation traps. Maskable requests come last. Each maskable request has a programmable level from 1 to 7, a routing bit and a mask-select bit.

Each handler has a valid/ready vector port. The controller raises `*_vld` once it has a winner. The registered vector then stays unchanged until the handler accepts it with `*_rdy`. The handler may hold `*_rdy` low for any number of cycles (back-pressure). There is one exception to the hold rule: if the presented request is withdrawn before acceptance, the vector turns into the spurious vector and stays there. On the processor side the controller keeps a record of the levels in service. An accepted maskable request raises the current level, and a return strobe drops back to the previous one. On the coprocessor side only one level of nesting is allowed.

Top module: `pvic_top`

## Requirements
- R1: Reset requests `rst_req[2:0]` beat every other source, and the lower index wins among them. Their vector offsets are 0xFE, 0xFC and 0xFA for indices 0, 1 and 2. Accepting a reset vector clears the processor's in-service levels to 0.
- R2: Non-maskable requests `nmi_req[5:0]` rank below resets and above all maskable requests, and the lower index wins among them. The offset of index j is 0xF8-2j. The masks and the current level do not gate them, and accepting one leaves `cpu_lvl` unchanged.
- R3: A write with `cfg_we=1` to address k < NUM_SRC sets source k. The data fields are [2:0] level, [3] route (1 = coprocessor) and [4] mask select (1 = X mask). A write to address NUM_SRC sets the vector base. A source whose level is 0 is never presented to either handler.
- R4: Among eligible maskable requests, the highest level wins. At equal levels the lower index wins. Source k uses offset 0xEC-2k.
- R5: A processor-routed request is presented only if its level is strictly above `cpu_lvl`. Accepting it makes its level the new `cpu_lvl`. A `cpu_ret` pulse restores the level that was current before that acceptance.
- R6: A processor-routed request is blocked while its selected mask (`x_mask` if its mask select bit is 1, otherwise `i_mask`) is 1.
- R7: A coprocessor-routed request is presented on the coprocessor port only if its level is above `cop_lvl` and `cop_nested` is 0. Accepting it while a coprocessor thread is running sets `cop_nested`. `cop_done` pops one level.
- R8: The vector equals base plus offset. While `*_vld` is 1 and `*_rdy` is 0, the vector holds steady, and a request of higher priority that arrives meanwhile is presented only after acceptance.
- R9: If the presented request drops before acceptance, the vector becomes base+0x10 (spurious) and `*_vld` stays 1. Accepting a spurious vector changes no level state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Source index, or NUM_SRC for the vector base |
| cfg_wdata | input | VEC_W | Write data |
| rst_req | input | 3 | Reset vector requests |
| nmi_req | input | 6 | Non-maskable trap requests |
| irq_req | input | NUM_SRC | Maskable requests |
| i_mask | input | 1 | Processor I mask bit |
| x_mask | input | 1 | Processor X mask bit |
| cpu_vld | output | 1 | Processor vector valid |
| cpu_rdy | input | 1 | Processor accepts vector |
| cpu_vec | output | VEC_W | Processor vector |
| cpu_ret | input | 1 | Processor return from maskable handler |
| cpu_lvl | output | 3 | Processor level in service |
| cop_vld | output | 1 | Coprocessor vector valid |
| cop_rdy | input | 1 | Coprocessor accepts vector |
| cop_vec | output | VEC_W | Coprocessor vector |
| cop_done | input | 1 | Coprocessor thread finished |
| cop_lvl | output | 3 | Coprocessor level in service |
| cop_nested | output | 1 | Coprocessor thread is nested |

## Verification
The bench builds the block with NUM_SRC=6 and VEC_W=16. With six sources there is enough room for two equal-level processor sources with different mask selects, one higher-level processor source, one source that can be disabled or moved to the coprocessor, and two coprocessor sources at different levels. That covers ties, masking, nesting on both sides and the one-deep coprocessor limit within a short run. A 16-bit base of 0xFF00 keeps every expected vector readable as 0xFFxx.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int N_RST = 3;
  localparam int N_NMI = 6;
  localparam int LVL_W = 3;
  localparam logic [7:0] OFS_RST0 = 8'hFE;
  localparam logic [7:0] OFS_NMI0 = 8'hF8;
  localparam logic [7:0] OFS_IRQ0 = 8'hEC;
  localparam logic [7:0] OFS_SPUR = 8'h10;

  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_SPUR} kind_e;

  // offset of the k-th source in a group whose first offset is first
  function automatic logic [7:0] grp_ofs(input logic [7:0] first, input logic [7:0] k);
    return first - (k << 1);
  endfunction
endpackage

// File: rtl/pvic_cfg_regs.sv
module pvic_cfg_regs #(
  parameter int N     = 8,
  parameter int VEC_W = 16,
  parameter int AW    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [AW-1:0]                      addr,
  input  logic [VEC_W-1:0]                   wdata,
  output logic [N-1:0][pvic_pkg::LVL_W-1:0]  lvl,
  output logic [N-1:0]                       route,
  output logic [N-1:0]                       xsel,
  output logic [VEC_W-1:0]                   base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= '0;
      route <= '0;
      xsel  <= '0;
      base  <= '0;
    end else if (we) begin
      for (int k = 0; k < N; k++) begin
        if (addr == AW'(k)) begin
          lvl[k]   <= wdata[2:0];
          route[k] <= wdata[3];
          xsel[k]  <= wdata[4];
        end
      end
      if (addr == AW'(N)) base <= wdata;
    end
  end
endmodule

// File: rtl/pvic_pick.sv
module pvic_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]                       elig,
  input  logic [N-1:0][pvic_pkg::LVL_W-1:0]  lvls,
  output logic                               any,
  output logic [IW-1:0]                      idx,
  output logic [pvic_pkg::LVL_W-1:0]         win_lvl
);
  // descending scan with >= leaves the lowest index on a tie
  always_comb begin
    any     = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[k] && lvls[k] >= win_lvl) begin
        any     = 1'b1;
        win_lvl = lvls[k];
        idx     = IW'(k);
      end
    end
  end
endmodule

// File: rtl/pvic_port.sv
module pvic_port #(
  parameter int VEC_W = 16,
  parameter int IW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [VEC_W-1:0]            base,
  input  logic                        cand_any,
  input  pvic_pkg::kind_e             cand_kind,
  input  logic [IW-1:0]               cand_idx,
  input  logic [pvic_pkg::LVL_W-1:0]  cand_lvl,
  input  logic [7:0]                  cand_ofs,
  input  logic                        held_live,
  input  logic                        rdy,
  output logic                        vld,
  output logic [VEC_W-1:0]            vec,
  output pvic_pkg::kind_e             h_kind,
  output logic [IW-1:0]               h_idx,
  output logic [pvic_pkg::LVL_W-1:0]  h_lvl,
  output logic                        acc
);
  import pvic_pkg::*;

  assign acc = vld && rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      vec    <= '0;
      h_kind <= K_SPUR;
      h_idx  <= '0;
      h_lvl  <= '0;
    end else if (!vld) begin
      if (cand_any) begin
        vld    <= 1'b1;
        vec    <= base + VEC_W'(cand_ofs);
        h_kind <= cand_kind;
        h_idx  <= cand_idx;
        h_lvl  <= cand_lvl;
      end
    end else if (rdy) begin
      vld <= 1'b0;
    end else if (h_kind != K_SPUR && !held_live) begin
      h_kind <= K_SPUR;
      vec    <= base + VEC_W'(OFS_SPUR);
    end
  end

  // presented vector only changes by turning spurious
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy |=> vld && ($stable(vec) || h_kind == K_SPUR));

  p_spur_from_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !rdy && h_kind != K_SPUR && !held_live |=> h_kind == K_SPUR);
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 16,
  localparam int AW     = $clog2(NUM_SRC + 1),
  localparam int IW     = ($clog2(NUM_SRC) > 3) ? $clog2(NUM_SRC) : 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [VEC_W-1:0]     cfg_wdata,
  input  logic [2:0]           rst_req,
  input  logic [5:0]           nmi_req,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic                 i_mask,
  input  logic                 x_mask,
  output logic                 cpu_vld,
  input  logic                 cpu_rdy,
  output logic [VEC_W-1:0]     cpu_vec,
  input  logic                 cpu_ret,
  output logic [2:0]           cpu_lvl,
  output logic                 cop_vld,
  input  logic                 cop_rdy,
  output logic [VEC_W-1:0]     cop_vec,
  input  logic                 cop_done,
  output logic [2:0]           cop_lvl,
  output logic                 cop_nested
);
  import pvic_pkg::*;

  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_SRC-1:0]            route, xsel;
  logic [VEC_W-1:0]              base;

  pvic_cfg_regs #(.N(NUM_SRC), .VEC_W(VEC_W), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lvl(lvl), .route(route), .xsel(xsel), .base(base)
  );

  // ---------------- eligibility ----------------
  logic [NUM_SRC-1:0] cpu_el, cop_el;
  logic [2:0]         cop_lvl_q, cop_sav_q;
  logic               cop_nest_q;

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      cpu_el[k] = irq_req[k] && lvl[k] != '0 && !route[k] &&
                  !(xsel[k] ? x_mask : i_mask) && lvl[k] > cpu_lvl;
      cop_el[k] = irq_req[k] && lvl[k] != '0 && route[k] &&
                  !cop_nest_q && lvl[k] > cop_lvl_q;
    end
  end

  logic          cpu_pany, cop_pany;
  logic [IW-1:0] cpu_pidx, cop_pidx;
  logic [2:0]    cpu_plvl, cop_plvl;

  pvic_pick #(.N(NUM_SRC), .IW(IW)) u_pick_cpu (
    .elig(cpu_el), .lvls(lvl), .any(cpu_pany), .idx(cpu_pidx), .win_lvl(cpu_plvl));
  pvic_pick #(.N(NUM_SRC), .IW(IW)) u_pick_cop (
    .elig(cop_el), .lvls(lvl), .any(cop_pany), .idx(cop_pidx), .win_lvl(cop_plvl));

  // ---------------- processor candidate: resets, traps, maskable ----------------
  logic          c_any;
  kind_e         c_kind;
  logic [IW-1:0] c_idx;
  logic [2:0]    c_lvl;
  logic [7:0]    c_ofs;

  always_comb begin
    c_any  = cpu_pany;
    c_kind = K_IRQ;
    c_idx  = cpu_pidx;
    c_lvl  = cpu_plvl;
    c_ofs  = grp_ofs(OFS_IRQ0, 8'(cpu_pidx));
    if (nmi_req != '0) begin
      c_any = 1'b1;
      c_kind = K_NMI;
      c_lvl = '0;
      for (int j = N_NMI - 1; j >= 0; j--)
        if (nmi_req[j]) begin
          c_idx = IW'(j);
          c_ofs = grp_ofs(OFS_NMI0, 8'(j));
        end
    end
    if (rst_req != '0) begin
      c_any = 1'b1;
      c_kind = K_RST;
      c_lvl = '0;
      for (int i = N_RST - 1; i >= 0; i--)
        if (rst_req[i]) begin
          c_idx = IW'(i);
          c_ofs = grp_ofs(OFS_RST0, 8'(i));
        end
    end
  end

  // ---------------- handler ports ----------------
  kind_e         cpu_hk, cop_hk;
  logic [IW-1:0] cpu_hi, cop_hi;
  logic [2:0]    cpu_hl, cop_hl;
  logic          cpu_acc, cop_acc, cpu_live, cop_live;

  always_comb begin
    cpu_live = 1'b1;
    cop_live = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cop_hi == IW'(k)) cop_live = irq_req[k];
      if (cpu_hk == K_IRQ && cpu_hi == IW'(k)) cpu_live = irq_req[k];
    end
    for (int j = 0; j < N_NMI; j++)
      if (cpu_hk == K_NMI && cpu_hi == IW'(j)) cpu_live = nmi_req[j];
    for (int i = 0; i < N_RST; i++)
      if (cpu_hk == K_RST && cpu_hi == IW'(i)) cpu_live = rst_req[i];
  end

  pvic_port #(.VEC_W(VEC_W), .IW(IW)) u_port_cpu (
    .clk(clk), .rst_n(rst_n), .base(base), .cand_any(c_any), .cand_kind(c_kind),
    .cand_idx(c_idx), .cand_lvl(c_lvl), .cand_ofs(c_ofs), .held_live(cpu_live),
    .rdy(cpu_rdy), .vld(cpu_vld), .vec(cpu_vec), .h_kind(cpu_hk), .h_idx(cpu_hi),
    .h_lvl(cpu_hl), .acc(cpu_acc)
  );

  pvic_port #(.VEC_W(VEC_W), .IW(IW)) u_port_cop (
    .clk(clk), .rst_n(rst_n), .base(base), .cand_any(cop_pany), .cand_kind(K_IRQ),
    .cand_idx(cop_pidx), .cand_lvl(cop_plvl), .cand_ofs(grp_ofs(OFS_IRQ0, 8'(cop_pidx))),
    .held_live(cop_live), .rdy(cop_rdy), .vld(cop_vld), .vec(cop_vec), .h_kind(cop_hk),
    .h_idx(cop_hi), .h_lvl(cop_hl), .acc(cop_acc)
  );

  // ---------------- processor in-service levels (bit per level) ----------------
  logic [7:1] svc_q, svc_d;

  always_comb begin
    cpu_lvl = '0;
    for (int l = 1; l <= 7; l++) if (svc_q[l]) cpu_lvl = 3'(l);
  end

  always_comb begin
    svc_d = svc_q;
    if (cpu_ret)
      for (int l = 1; l <= 7; l++) if (cpu_lvl == 3'(l)) svc_d[l] = 1'b0;
    if (cpu_acc && cpu_hk == K_IRQ)
      for (int l = 1; l <= 7; l++) if (cpu_hl == 3'(l)) svc_d[l] = 1'b1;
    if (cpu_acc && cpu_hk == K_RST) svc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  // ---------------- coprocessor one-deep nesting ----------------
  logic [2:0] cop_lvl_d, cop_sav_d;
  logic       cop_nest_d;

  always_comb begin
    cop_lvl_d  = cop_lvl_q;
    cop_sav_d  = cop_sav_q;
    cop_nest_d = cop_nest_q;
    if (cop_done) begin
      if (cop_nest_q) begin
        cop_lvl_d  = cop_sav_q;
        cop_nest_d = 1'b0;
      end else begin
        cop_lvl_d = '0;
      end
    end
    if (cop_acc && cop_hk == K_IRQ) begin
      if (cop_lvl_d != '0) begin
        cop_sav_d  = cop_lvl_d;
        cop_nest_d = 1'b1;
      end
      cop_lvl_d = cop_hl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_lvl_q  <= '0;
      cop_sav_q  <= '0;
      cop_nest_q <= 1'b0;
    end else begin
      cop_lvl_q  <= cop_lvl_d;
      cop_sav_q  <= cop_sav_d;
      cop_nest_q <= cop_nest_d;
    end
  end

  assign cop_lvl    = cop_lvl_q;
  assign cop_nested = cop_nest_q;

  // ---------------- checks ----------------
  p_cop_one_deep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cop_nested |-> !cop_vld);

  p_nest_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_vld && cpu_hk == K_IRQ |-> cpu_hl > cpu_lvl);

  p_lvl_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ret && !(cpu_acc && cpu_hk == K_RST) |=> cpu_lvl >= $past(cpu_lvl));

  p_spur_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_acc && cpu_hk == K_SPUR && !cpu_ret |=> $stable(cpu_lvl));

  p_rst_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_acc && cpu_hk == K_RST |=> cpu_lvl == 3'd0);
endmodule

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
  localparam int N  = 6;
  localparam int VW = 16;
  localparam int AW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [VW-1:0] cfg_wdata = '0;
  logic [2:0] rst_req = '0;
  logic [5:0] nmi_req = '0;
  logic [N-1:0] irq_req = '0;
  logic i_mask = 1'b0, x_mask = 1'b0;
  logic cpu_rdy = 1'b0, cpu_ret = 1'b0, cop_rdy = 1'b0, cop_done = 1'b0;
  logic cpu_vld, cop_vld, cop_nested;
  logic [VW-1:0] cpu_vec, cop_vec;
  logic [2:0] cpu_lvl, cop_lvl;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  pvic_top #(.NUM_SRC(N), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req), .i_mask(i_mask),
    .x_mask(x_mask), .cpu_vld(cpu_vld), .cpu_rdy(cpu_rdy), .cpu_vec(cpu_vec),
    .cpu_ret(cpu_ret), .cpu_lvl(cpu_lvl), .cop_vld(cop_vld), .cop_rdy(cop_rdy),
    .cop_vec(cop_vec), .cop_done(cop_done), .cop_lvl(cop_lvl), .cop_nested(cop_nested)
  );

  task automatic ceq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg(input int a, input logic [VW-1:0] d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cpu_take(input string rq, input logic [VW-1:0] exp);
    ceq(rq, {31'd0, cpu_vld}, 32'd1);
    ceq(rq, cpu_vec, exp);
    cpu_rdy = 1'b1; step(); cpu_rdy = 1'b0;
  endtask

  task automatic cop_take(input string rq, input logic [VW-1:0] exp);
    ceq(rq, {31'd0, cop_vld}, 32'd1);
    ceq(rq, cop_vec, exp);
    cop_rdy = 1'b1; step(); cop_rdy = 1'b0;
  endtask

  task automatic ret();
    cpu_ret = 1'b1; step(); cpu_ret = 1'b0;
  endtask

  task automatic done();
    cop_done = 1'b1; step(); cop_done = 1'b0;
  endtask

  task automatic t_reset();
    ceq("R8 reset cpu_vld", cpu_vld, 0);
    ceq("R8 reset cop_vld", cop_vld, 0);
    ceq("R5 reset cpu_lvl", cpu_lvl, 0);
    ceq("R7 reset cop_lvl", cop_lvl, 0);
  endtask

  task automatic t_setup();
    cfg(N, 16'hFF00);        // R3 base
    cfg(0, 16'h0003);        // lvl3 cpu I
    cfg(1, 16'h0013);        // lvl3 cpu X
    cfg(2, 16'h0005);        // lvl5 cpu I
    cfg(3, 16'h0000);        // disabled
    cfg(4, 16'h000A);        // lvl2 cop
    cfg(5, 16'h000C);        // lvl4 cop
  endtask

  // R1 R2 R4: everything at once
  task automatic t_simultaneous();
    rst_req = 3'b110; nmi_req = 6'b000001; irq_req[2] = 1'b1;
    step();
    cpu_take("R1 rst1 first", 16'hFFFC);
    rst_req = 3'b100; step();
    cpu_take("R1 rst2 next", 16'hFFFA);
    rst_req = 3'b000; step();
    cpu_take("R2 nmi0 after resets", 16'hFFF8);
    nmi_req = '0; step();
    ceq("R2 nmi keeps level", cpu_lvl, 0);
    cpu_take("R4 irq2 last", 16'hFFE8);
    irq_req = '0;
    ceq("R5 level raised", cpu_lvl, 5);
    ret();
    ceq("R5 level restored", cpu_lvl, 0);
  endtask

  // R4 tie, R8 hold, R5 nesting
  task automatic t_tie_nest();
    irq_req[0] = 1'b1; irq_req[1] = 1'b1; step();
    ceq("R4 tie lower index", cpu_vec, 16'hFFEC);
    irq_req[2] = 1'b1; step();
    ceq("R8 held vld", cpu_vld, 1);
    ceq("R8 held vector", cpu_vec, 16'hFFEC);
    cpu_take("R4 take src0", 16'hFFEC);
    irq_req[0] = 1'b0;
    ceq("R5 lvl3", cpu_lvl, 3);
    step();
    cpu_take("R5 nested higher", 16'hFFE8);
    irq_req[2] = 1'b0;
    ceq("R5 lvl5", cpu_lvl, 5);
    ret();
    ceq("R5 back to 3", cpu_lvl, 3);
    step();
    ceq("R5 equal level blocked", cpu_vld, 0);
    ret(); step();
    cpu_take("R5 src1 after return", 16'hFFEA);
    irq_req[1] = 1'b0;
    ret();
    ceq("R5 lvl0", cpu_lvl, 0);
  endtask

  // R3 level change while a request waits
  task automatic t_level_change();
    irq_req[2] = 1'b1; step();
    cpu_take("R5 src2", 16'hFFE8);
    irq_req[2] = 1'b0;
    irq_req[0] = 1'b1; step(); step();
    ceq("R5 lower waits", cpu_vld, 0);
    cfg(0, 16'h0006); step();
    cpu_take("R3 raised level presented", 16'hFFEC);
    irq_req[0] = 1'b0;
    ceq("R5 lvl6", cpu_lvl, 6);
    ret();
    ceq("R5 restore 5", cpu_lvl, 5);
    ret();
    ceq("R5 restore 0", cpu_lvl, 0);
    cfg(0, 16'h0003);
  endtask

  // R6 masks, R2 traps ignore masks
  task automatic t_masks();
    i_mask = 1'b1; irq_req[0] = 1'b1; irq_req[1] = 1'b1; step();
    cpu_take("R6 I mask leaves X source", 16'hFFEA);
    irq_req = '0;
    ret();
    x_mask = 1'b1; irq_req[1] = 1'b1; step(); step();
    ceq("R6 both masked", cpu_vld, 0);
    nmi_req[3] = 1'b1; step();
    cpu_take("R2 trap3 unmasked", 16'hFFF2);
    nmi_req = '0; irq_req = '0; i_mask = 1'b0; x_mask = 1'b0;
    step();
    ceq("R2 trap level", cpu_lvl, 0);
  endtask

  // R3 level 0 disables
  task automatic t_disabled();
    irq_req[3] = 1'b1; step(); step();
    ceq("R3 disabled cpu", cpu_vld, 0);
    ceq("R3 disabled cop", cop_vld, 0);
    irq_req[3] = 1'b0;
  endtask

  // R7 coprocessor one-deep
  task automatic t_cop();
    cfg(3, 16'h000F);
    irq_req[4] = 1'b1; step();
    ceq("R7 not on cpu", cpu_vld, 0);
    cop_take("R7 cop src4", 16'hFFE4);
    irq_req[4] = 1'b0;
    ceq("R7 cop lvl2", cop_lvl, 2);
    ceq("R7 not nested", cop_nested, 0);
    irq_req[5] = 1'b1; step();
    cop_take("R7 cop src5", 16'hFFE2);
    irq_req[5] = 1'b0;
    ceq("R7 cop lvl4", cop_lvl, 4);
    ceq("R7 nested", cop_nested, 1);
    irq_req[3] = 1'b1; step(); step();
    ceq("R7 second nest blocked", cop_vld, 0);
    done();
    ceq("R7 pop to 2", cop_lvl, 2);
    step();
    cop_take("R7 src3 after pop", 16'hFFE6);
    irq_req[3] = 1'b0;
    ceq("R7 lvl7", cop_lvl, 7);
    done();
    ceq("R7 back 2", cop_lvl, 2);
    ceq("R7 unnested", cop_nested, 0);
    done();
    ceq("R7 idle", cop_lvl, 0);
    cfg(3, 16'h0000);
  endtask

  // R9 spurious
  task automatic t_spurious();
    irq_req[2] = 1'b1; step();
    ceq("R9 presented", cpu_vec, 16'hFFE8);
    irq_req[2] = 1'b0; step();
    cpu_take("R9 spurious vector", 16'hFF10);
    ceq("R9 level unchanged", cpu_lvl, 0);
    step();
    ceq("R9 idle after", cpu_vld, 0);
  endtask

  // R1 reset acceptance clears level
  task automatic t_reset_clear();
    irq_req[2] = 1'b1; step();
    cpu_take("R5 src2 again", 16'hFFE8);
    irq_req[2] = 1'b0;
    ceq("R5 lvl5 again", cpu_lvl, 5);
    rst_req = 3'b001; step();
    cpu_take("R1 rst0", 16'hFFFE);
    rst_req = '0;
    ceq("R1 level cleared", cpu_lvl, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_setup();
    t_simultaneous();
    t_tie_nest();
    t_level_change();
    t_masks();
    t_disabled();
    t_cop();
    t_spurious();
    t_reset_clear();
    report();
  end
endmodule